// File: doc/BRIEF.md
# Multi-Port Hardware Spin-Lock Bank

This block gives several processors mutual exclusion even though none of them has an atomic read-modify-write instruction. Each processor has its own slave port with an address, a read strobe, a write strobe, write data and read data. Every port sees the same bank of independent lock bits.

To acquire a lock, a processor reads that lock's address. The device performs the test-and-set itself, inside one clock cycle, for all ports at once. It returns 1 when the caller now owns the lock and 0 when the attempt failed. To release the lock, the owner writes to the same address. Software spins on the read until it sees 1.

Each lock remembers which port owns it, so a stray write from any other port cannot free it. When several ports contend for the same free lock in one cycle, a fixed priority picks a single winner. Contention on different locks never interacts.

Top module: `spinlock_bank`

## Requirements
- R1: The bank has NUM_LOCKS (default 16) locks. The unsigned value on a port's address field (ADDR_W = 4 bits by default) selects lock of that index, and every port uses the identical map.
- R2: A read of a free lock makes the reading port its owner. The port's read data in the following cycle is 1 in bit 0 with all other bits 0.
- R3: A read of a lock held by another port returns 0 and leaves the lock held by its owner.
- R4: A write by the owning port to a held lock frees it, whatever the write data value.
- R5: A write to a lock by a port that does not own it, or to a free lock, changes nothing.
- R6: When two or more ports read the same free lock in one cycle, the lowest-numbered port wins and reads 1. Every other contender reads 0.
- R7: A further read by the current owner returns 0 and the lock stays held by that owner (no recursion).
- R8: Reads of distinct free locks in the same cycle by different ports all succeed independently.
- R9: Read data is registered, valid exactly one cycle after the read strobe, and 0 in any cycle that does not follow a read on that port. After reset every lock is free and all read data is 0.
- R10: When the owner releases a lock in the same cycle that another port reads it, that read returns 0 and the lock is free afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_addr | input | NUM_PORTS x ADDR_W | Lock index per port |
| port_read | input | NUM_PORTS | Read strobe per port (test-and-set) |
| port_write | input | NUM_PORTS | Write strobe per port (release) |
| port_wdata | input | NUM_PORTS x DATA_W | Write data per port, value not used |
| port_rdata | output | NUM_PORTS x DATA_W | Acquire result per port, one cycle after the read |

## Verification
Two kinds of event can land on one lock in the same cycle: a test-and-set by several ports, and a release by the owner together with a test-and-set by another port. The bench drives three ports in lockstep, aiming simultaneous reads at one free lock and at distinct free locks, and pairing an owner's release with a rival's read. A scoreboard checks each outcome against the priority and ordering rules. It then confirms the resulting lock state with follow-up reads through the ports.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

    typedef enum logic {
        LOCK_FREE = 1'b0,
        LOCK_HELD = 1'b1
    } lock_state_e;

endpackage

// File: rtl/spinlock_prio_arb.sv
module spinlock_prio_arb #(
    parameter int N   = 2,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic             enable,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx
);

    logic [N-1:0] lowest;

    assign lowest = req & (~req + N'(1));
    assign grant  = enable ? lowest : '0;

    always_comb begin
        grant_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                grant_idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/spinlock_cell.sv
module spinlock_cell
    import spinlock_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] rd_req,
    input  logic [NUM_PORTS-1:0] wr_req,
    output logic [NUM_PORTS-1:0] grant
);

    typedef struct packed {
        lock_state_e       state;
        logic [PORT_W-1:0] owner;
    } cell_t;

    cell_t             cell_d;
    cell_t             cell_q;
    logic [PORT_W-1:0] win_idx;
    logic              release_ok;

    spinlock_prio_arb #(
        .N     (NUM_PORTS),
        .IDX_W (PORT_W)
    ) u_arb (
        .req       (rd_req),
        .enable    (cell_q.state == LOCK_FREE),
        .grant     (grant),
        .grant_idx (win_idx)
    );

    always_comb begin
        cell_d     = cell_q;
        release_ok = (cell_q.state == LOCK_HELD) && wr_req[cell_q.owner];
        if (cell_q.state == LOCK_FREE && (|rd_req)) begin
            cell_d.state = LOCK_HELD;
            cell_d.owner = win_idx;
        end else if (release_ok) begin
            cell_d.state = LOCK_FREE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '{state: LOCK_FREE, owner: '0};
        end else begin
            cell_q <= cell_d;
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6

    AST_NO_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q.state == LOCK_HELD) |-> (grant == '0)); // R3

    AST_ACQUIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> (cell_q.state == LOCK_HELD)); // R2

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q.state == LOCK_HELD && !wr_req[cell_q.owner])
        |=> (cell_q.state == LOCK_HELD && $stable(cell_q.owner))); // R5

    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q.state == LOCK_HELD && wr_req[cell_q.owner])
        |=> (cell_q.state == LOCK_FREE)); // R4

endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_LOCKS = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  port_addr,
    input  logic [NUM_PORTS-1:0]              port_read,
    input  logic [NUM_PORTS-1:0]              port_write,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  port_wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  port_rdata
);

    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        logic [NUM_PORTS-1:0] won;
    } resp_t;

    logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] rd_hit;
    logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] wr_hit;
    logic [NUM_LOCKS-1:0][NUM_PORTS-1:0] lock_grant;
    resp_t                               resp_d;
    resp_t                               resp_q;
    logic                                wdata_unused;

    assign wdata_unused = ^port_wdata;

    for (genvar li = 0; li < NUM_LOCKS; li++) begin : g_lock
        for (genvar pi = 0; pi < NUM_PORTS; pi++) begin : g_hit
            assign rd_hit[li][pi] = port_read[pi]  && (port_addr[pi] == ADDR_W'(li));
            assign wr_hit[li][pi] = port_write[pi] && (port_addr[pi] == ADDR_W'(li));
        end

        spinlock_cell #(
            .NUM_PORTS (NUM_PORTS),
            .PORT_W    (PORT_W)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_req (rd_hit[li]),
            .wr_req (wr_hit[li]),
            .grant  (lock_grant[li])
        );
    end

    always_comb begin
        resp_d = '0;
        for (int l = 0; l < NUM_LOCKS; l++) begin
            resp_d.won = resp_d.won | lock_grant[l];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    for (genvar po = 0; po < NUM_PORTS; po++) begin : g_out
        assign port_rdata[po] = {{(DATA_W-1){1'b0}}, resp_q.won[po]};

        AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !port_read[po] |=> (port_rdata[po] == '0)); // R9
    end

endmodule

// File: tb/spinlock_bank_bench.sv
module spinlock_bank_bench;

    localparam int NP = 3;
    localparam int NL = 16;
    localparam int DW = 32;
    localparam int AW = 4;

    typedef struct {
        logic [NP-1:0] exp;
        string         tag;
    } item_t;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NP-1:0][AW-1:0]     port_addr = '0;
    logic [NP-1:0]             port_read = '0;
    logic [NP-1:0]             port_write = '0;
    logic [NP-1:0][DW-1:0]     port_wdata = '0;
    logic [NP-1:0][DW-1:0]     port_rdata;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    spinlock_bank #(
        .NUM_PORTS (NP),
        .NUM_LOCKS (NL),
        .DATA_W    (DW)
    ) u_spinlock_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_addr  (port_addr),
        .port_read  (port_read),
        .port_write (port_write),
        .port_wdata (port_wdata),
        .port_rdata (port_rdata)
    );

    task automatic step(input logic [NP-1:0] rd, input logic [NP-1:0] wr,
                        input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [AW-1:0] a2, input logic [NP-1:0] exp,
                        input string tag);
        item_t it;
        @(negedge clk);
        port_read  = rd;
        port_write = wr;
        port_addr  = {a2, a1, a0};
        port_wdata = {32'hFFFF_0000 + DW'(total), 32'h0, 32'h1234_5678};
        @(posedge clk);
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            for (int p = 0; p < NP; p++) begin
                logic [DW-1:0] want;
                want = {{(DW-1){1'b0}}, it.exp[p]};
                total++;
                if (port_rdata[p] !== want) begin
                    bad++;
                    $display("FAIL %s port%0d: got %h expected %h", it.tag, p, port_rdata[p], want);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            total++;
            if (port_rdata[p] !== '0) begin
                bad++;
                $display("FAIL R9 reset port%0d: got %h expected 0", p, port_rdata[p]);
            end
        end
        step(3'b010, 3'b000, 4'd0, 4'd5, 4'd0, 3'b010, "R2");
        step(3'b010, 3'b000, 4'd0, 4'd5, 4'd0, 3'b000, "R7");
        step(3'b001, 3'b000, 4'd5, 4'd0, 4'd0, 3'b000, "R3");
        step(3'b000, 3'b100, 4'd0, 4'd0, 4'd5, 3'b000, "R5");
        step(3'b001, 3'b000, 4'd5, 4'd0, 4'd0, 3'b000, "R5");
        step(3'b000, 3'b010, 4'd0, 4'd5, 4'd0, 3'b000, "R4");
        step(3'b001, 3'b000, 4'd5, 4'd0, 4'd0, 3'b001, "R4");
        step(3'b111, 3'b000, 4'd9, 4'd9, 4'd9, 3'b001, "R6");
        step(3'b110, 3'b000, 4'd0, 4'd9, 4'd9, 3'b000, "R6");
        step(3'b110, 3'b000, 4'd0, 4'd10, 4'd10, 3'b010, "R6");
        step(3'b111, 3'b000, 4'd0, 4'd15, 4'd3, 3'b111, "R8");
        step(3'b000, 3'b000, 4'd0, 4'd0, 4'd0, 3'b000, "R9");
        step(3'b100, 3'b001, 4'd0, 4'd0, 4'd0, 3'b000, "R10");
        step(3'b100, 3'b000, 4'd0, 4'd0, 4'd0, 3'b100, "R10");
        step(3'b000, 3'b010, 4'd0, 4'd7, 4'd0, 3'b000, "R5");
        step(3'b010, 3'b000, 4'd0, 4'd7, 4'd0, 3'b010, "R5");
        step(3'b000, 3'b100, 4'd0, 4'd0, 4'd15, 3'b000, "R1");
        step(3'b100, 3'b000, 4'd0, 4'd0, 4'd15, 3'b000, "R1");
        step(3'b000, 3'b010, 4'd0, 4'd15, 4'd0, 3'b000, "R1");
        step(3'b100, 3'b000, 4'd0, 4'd0, 4'd15, 3'b100, "R1");
        step(3'b000, 3'b000, 4'd0, 4'd0, 4'd0, 3'b000, "R9");
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule